// File: doc/BRIEF.md
# SRAM Write-Readback Verify Sequencer

This block is a self-test engine placed in front of an external SRAM controller. After a start pulse it visits every location of two banks. At each location it writes the constant byte 0xFF, reads the same location straight back, and compares the returned byte with the pattern. The first bank is swept with the bank bit low. When its offset wraps, the second bank is swept with the bank bit high.

Each access is a request held towards the memory controller until the controller returns a one-cycle completion. On the first mismatch the engine stops for good, raises a fail flag and holds the bank and offset of the bad location. If both banks complete cleanly it stops with a pass flag. The bank depth is a parameter, so shortened sweeps are possible.

Top module: `sram_bist_seq`

## Requirements
- R1: While reset is asserted and afterwards until a start pulse, `mem_req_o`, `done_o`, `pass_o` and `fail_o` are low and `fail_addr_o` is zero.
- R2: A start pulse sampled while idle, passed or failed clears `done_o`, `pass_o`, `fail_o` and `fail_addr_o`. In the next cycle it issues a write request to bank 0, offset 0.
- R3: For every location the engine raises a write request (`mem_we_o`=1, `mem_wdata_o`=0xFF). In the cycle after that write completes, it raises a read request (`mem_we_o`=0) to the same address.
- R4: The byte returned with a read's completion is compared one cycle later. On a match the write request for the next location starts in the following cycle.
- R5: Offsets run upward from 0 to BANK_DEPTH-1 with the bank bit (`mem_addr_o[OFFS_W]`) at 0. Then the offset restarts at 0 with the bank bit at 1. Each location is written exactly once per clean sweep, 2*BANK_DEPTH writes in all.
- R6: After the last location of bank 1 compares equal, `done_o` and `pass_o` rise and stay high, and no further requests are issued until the next start.
- R7: On a mismatch, `fail_o` and `done_o` rise and `fail_addr_o` holds {bank bit, offset} of that location. No further requests are issued until the next start.
- R8: The compared byte is the one present on `mem_rdata_i` in the completion cycle of the current read. The capture register holds zero throughout each read request.
- R9: A start pulse while a sweep is running has no effect: the address order and the number of writes are unchanged.
- R10: While a request is waiting for its completion, `mem_req_o`, `mem_we_o` and `mem_addr_o` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse for a new sweep |
| mem_req_o | output | 1 | Access request to memory controller, held until completion |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | OFFS_W+1 | {bank bit, offset} |
| mem_wdata_o | output | DATA_W | Write data (pattern) |
| mem_done_i | input | 1 | One-cycle completion of the pending access |
| mem_rdata_i | input | DATA_W | Read data, valid with completion |
| done_o | output | 1 | Sweep ended (pass or fail) |
| pass_o | output | 1 | Both banks verified |
| fail_o | output | 1 | Mismatch found |
| fail_addr_o | output | OFFS_W+1 | {bank bit, offset} of the failing location |

## Verification
The hardest situations to reach are a mismatch at the last offset of the second bank, and a restart pulse arriving in the middle of a sweep. Both need the engine to have walked most of the address space first. The bench uses a shortened bank depth and a memory model that corrupts the read of one chosen location. Completion latency is varied per sweep. Between completions the read-data bus carries a non-pattern value, so a byte sampled at the wrong time shows up as a failure.

// File: rtl/sram_bist_pkg.sv
package sram_bist_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WRITE,
    ST_READ,
    ST_CHECK,
    ST_PASS,
    ST_FAIL
  } state_e;
endpackage

// File: rtl/sram_bist_addr_gen.sv
module sram_bist_addr_gen #(
  parameter int OFFS_W     = 16,
  parameter int BANK_DEPTH = 65536
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              step_i,
  output logic [OFFS_W-1:0] off_o,
  output logic              bank_o,
  output logic              final_o
);
  localparam logic [OFFS_W-1:0] LAST_OFF = OFFS_W'(BANK_DEPTH - 1);

  logic [OFFS_W-1:0] off_q;
  logic              bank_q;
  logic              last;

  generate
    if (BANK_DEPTH == (1 << OFFS_W)) begin : g_full
      assign last = &off_q;
    end else begin : g_short
      assign last = (off_q == LAST_OFF);
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_q  <= '0;
      bank_q <= 1'b0;
    end else if (clr_i) begin
      off_q  <= '0;
      bank_q <= 1'b0;
    end else if (step_i) begin
      if (last) begin
        off_q  <= '0;
        bank_q <= 1'b1;
      end else begin
        off_q <= off_q + 1'b1;
      end
    end
  end

  assign off_o   = off_q;
  assign bank_o  = bank_q;
  assign final_o = last & bank_q;
endmodule

// File: rtl/sram_bist_cmp.sv
module sram_bist_cmp #(
  parameter int              DATA_W  = 8,
  parameter logic [DATA_W-1:0] PATTERN = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [DATA_W-1:0] cap_o,
  output logic              mismatch_o
);
  logic [DATA_W-1:0] cap_q;

  // cleared ahead of each read so a stale byte never matches
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cap_q <= '0;
    else if (clr_i)   cap_q <= '0;
    else if (load_i)  cap_q <= rdata_i;
  end

  assign cap_o      = cap_q;
  assign mismatch_o = (cap_q != PATTERN);
endmodule

// File: rtl/sram_bist_ctrl.sv
module sram_bist_ctrl
  import sram_bist_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_i,
  input  logic   mem_done_i,
  input  logic   mismatch_i,
  input  logic   final_i,
  output state_e state_o,
  output logic   addr_clr_o,
  output logic   step_o,
  output logic   cap_clr_o,
  output logic   cap_load_o,
  output logic   fail_latch_o
);
  state_e state_q, state_d;

  always_comb begin
    state_d      = state_q;
    addr_clr_o   = 1'b0;
    step_o       = 1'b0;
    cap_clr_o    = 1'b0;
    cap_load_o   = 1'b0;
    fail_latch_o = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_PASS, ST_FAIL: begin
        if (start_i) begin
          state_d    = ST_WRITE;
          addr_clr_o = 1'b1;
        end
      end
      ST_WRITE: begin
        if (mem_done_i) begin
          state_d   = ST_READ;
          cap_clr_o = 1'b1;
        end
      end
      ST_READ: begin
        if (mem_done_i) begin
          state_d    = ST_CHECK;
          cap_load_o = 1'b1;
        end
      end
      ST_CHECK: begin
        if (mismatch_i) begin
          state_d      = ST_FAIL;
          fail_latch_o = 1'b1;
        end else if (final_i) begin
          state_d = ST_PASS;
        end else begin
          state_d = ST_WRITE;
          step_o  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/sram_bist_seq.sv
module sram_bist_seq
  import sram_bist_pkg::*;
#(
  parameter int                OFFS_W     = 16,
  parameter int                DATA_W     = 8,
  parameter int                BANK_DEPTH = 65536,
  parameter logic [DATA_W-1:0] PATTERN    = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [OFFS_W:0]   mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_done_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              done_o,
  output logic              pass_o,
  output logic              fail_o,
  output logic [OFFS_W:0]   fail_addr_o
);
  localparam int AW = OFFS_W + 1;

  state_e            state;
  logic              addr_clr, step, cap_clr, cap_load, fail_latch;
  logic [OFFS_W-1:0] off;
  logic              bank, final_loc, mismatch;
  logic [DATA_W-1:0] cap_q;
  logic [AW-1:0]     fail_addr_q;

  sram_bist_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .mem_done_i   (mem_done_i),
    .mismatch_i   (mismatch),
    .final_i      (final_loc),
    .state_o      (state),
    .addr_clr_o   (addr_clr),
    .step_o       (step),
    .cap_clr_o    (cap_clr),
    .cap_load_o   (cap_load),
    .fail_latch_o (fail_latch)
  );

  sram_bist_addr_gen #(
    .OFFS_W     (OFFS_W),
    .BANK_DEPTH (BANK_DEPTH)
  ) u_addr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (addr_clr),
    .step_i  (step),
    .off_o   (off),
    .bank_o  (bank),
    .final_o (final_loc)
  );

  sram_bist_cmp #(
    .DATA_W  (DATA_W),
    .PATTERN (PATTERN)
  ) u_cmp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (cap_clr),
    .load_i     (cap_load),
    .rdata_i    (mem_rdata_i),
    .cap_o      (cap_q),
    .mismatch_o (mismatch)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         fail_addr_q <= '0;
    else if (addr_clr)   fail_addr_q <= '0;
    else if (fail_latch) fail_addr_q <= {bank, off};
  end

  assign mem_req_o   = (state == ST_WRITE) || (state == ST_READ);
  assign mem_we_o    = (state == ST_WRITE);
  assign mem_addr_o  = {bank, off};
  assign mem_wdata_o = PATTERN;
  assign pass_o      = (state == ST_PASS);
  assign fail_o      = (state == ST_FAIL);
  assign done_o      = pass_o | fail_o;
  assign fail_addr_o = fail_addr_q;
endmodule

// File: rtl/sram_bist_chk.sv
module sram_bist_chk #(
  parameter int OFFS_W = 16,
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [OFFS_W:0]   mem_addr_o,
  input logic              mem_done_i,
  input logic              done_o,
  input logic              pass_o,
  input logic              fail_o,
  input logic [OFFS_W:0]   fail_addr_o,
  input logic [DATA_W-1:0] cap_q
);
  p_req_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_done_i |=> mem_req_o && $stable(mem_we_o) && $stable(mem_addr_o));

  p_readback_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o && mem_done_i |=> mem_req_o && !mem_we_o && $stable(mem_addr_o));

  p_cap_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_we_o |-> cap_q == '0);

  p_quiet_end_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !mem_req_o);

  p_end_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> done_o && $stable(pass_o) && $stable(fail_addr_o));

  p_pass_clean_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_o |-> fail_addr_o == '0 && !fail_o);

  p_fail_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> done_o && !pass_o);
endmodule

bind sram_bist_seq sram_bist_chk #(
  .OFFS_W (OFFS_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_done_i  (mem_done_i),
  .done_o      (done_o),
  .pass_o      (pass_o),
  .fail_o      (fail_o),
  .fail_addr_o (fail_addr_o),
  .cap_q       (cap_q)
);

// File: tb/sram_bist_seq_bench.sv
`timescale 1ns/1ps
module sram_bist_seq_bench;
  localparam int OW    = 16;
  localparam int DW    = 8;
  localparam int DEPTH = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          req, we, done_o, pass_o, fail_o;
  logic [OW:0]   addr, faddr;
  logic [DW-1:0] wdata;
  logic          done_q;
  logic [DW-1:0] rdata_q;

  always #2.5 clk = ~clk;

  sram_bist_seq #(
    .OFFS_W (OW), .DATA_W (DW), .BANK_DEPTH (DEPTH), .PATTERN (8'hFF)
  ) u_sram_bist_seq (
    .clk_i (clk), .rst_ni (rst_n), .start_i (start),
    .mem_req_o (req), .mem_we_o (we), .mem_addr_o (addr), .mem_wdata_o (wdata),
    .mem_done_i (done_q), .mem_rdata_i (rdata_q),
    .done_o (done_o), .pass_o (pass_o), .fail_o (fail_o), .fail_addr_o (faddr)
  );

  int n_total = 0;
  int n_bad   = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_total++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // memory model with controllable latency and one corrupted location
  logic [DW-1:0] mem [0:2*DEPTH-1];
  int            lat = 0;
  int            cnt;
  int            fault_idx = -1;
  logic [DW-1:0] fault_mask = '0;
  int            wr_cnt;
  logic          mem_clr = 1'b0;

  function automatic int idx_of(logic [OW:0] a);
    return int'(a[OW]) * DEPTH + int'(a[OW-1:0]);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      cnt     <= 0;
      rdata_q <= '0;
      wr_cnt  <= 0;
    end else begin
      if (mem_clr) begin
        for (int i = 0; i < 2*DEPTH; i++) mem[i] <= '0;
      end
      if (done_q) begin
        done_q  <= 1'b0;
        cnt     <= 0;
        rdata_q <= '0;
      end else if (req) begin
        if (cnt >= lat) begin
          done_q <= 1'b1;
          if (we) begin
            mem[idx_of(addr)] <= wdata;
            wr_cnt <= wr_cnt + 1;
          end else begin
            rdata_q <= (idx_of(addr) == fault_idx) ? (mem[idx_of(addr)] ^ fault_mask)
                                                   : mem[idx_of(addr)];
          end
        end else begin
          cnt <= cnt + 1;
        end
      end
    end
  end

  // behavioural reference: 0 idle, 1 write, 2 read, 3 compare, 4 pass, 5 fail
  int          m_ph, m_off, m_bank;
  logic [DW-1:0] m_got;
  longint      m_faddr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_off = 0; m_bank = 0; m_got = '0; m_faddr = 0;
    end else begin
      case (m_ph)
        0, 4, 5: if (start) begin m_ph = 1; m_off = 0; m_bank = 0; m_faddr = 0; end
        1: if (done_q) m_ph = 2;
        2: if (done_q) begin m_got = rdata_q; m_ph = 3; end
        3: begin
          if (m_got != 8'hFF) begin
            m_ph = 5; m_faddr = (longint'(m_bank) << OW) | m_off;
          end else if (m_off == DEPTH-1) begin
            if (m_bank == 1) m_ph = 4;
            else begin m_bank = 1; m_off = 0; m_ph = 1; end
          end else begin
            m_off++; m_ph = 1;
          end
        end
        default: m_ph = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      automatic bit e_req = (m_ph == 1) || (m_ph == 2);
      chk(req == e_req, "R4 req", req, e_req);
      if (e_req) begin
        chk(we == (m_ph == 1), "R3 we", we, m_ph == 1);
        chk(addr == ((m_bank << OW) | m_off), "R5 addr", addr, (m_bank << OW) | m_off);
        if (m_ph == 1) chk(wdata == 8'hFF, "R3 wdata", wdata, 8'hFF);
      end
      chk(pass_o == (m_ph == 4), "R6 pass", pass_o, m_ph == 4);
      chk(fail_o == (m_ph == 5), "R7 fail", fail_o, m_ph == 5);
      chk(done_o == (m_ph >= 4), "R6 done", done_o, m_ph >= 4);
      chk(faddr == m_faddr, "R7 fail_addr", faddr, m_faddr);
    end
  end

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", n_total, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_total++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  task automatic prep(input int l, input int fidx, input logic [DW-1:0] fmask);
    lat = l; fault_idx = fidx; fault_mask = fmask;
    @(negedge clk) mem_clr = 1'b1;
    @(negedge clk) mem_clr = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_end();
    while (!done_o) @(negedge clk);
  endtask

  task automatic quiet_after(input string tag);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk(!req, tag, req, 0);
    end
  endtask

  initial begin
    int base;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(!req && !done_o && !pass_o && !fail_o, "R1 reset outputs", {req, done_o, pass_o, fail_o}, 0);
    chk(faddr == 0, "R1 reset fail_addr", faddr, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!req && !done_o, "R1 idle before start", {req, done_o}, 0);

    // clean sweep, zero latency
    prep(0, -1, '0);
    base = wr_cnt;
    pulse_start();
    chk(req && we && addr == 0, "R2 first write at bank0 offset0", addr, 0);
    wait_end();
    chk(pass_o && !fail_o, "R6 clean sweep passes", {pass_o, fail_o}, 2);
    chk(wr_cnt - base == 2*DEPTH, "R5 write count", wr_cnt - base, 2*DEPTH);
    for (int i = 0; i < 2*DEPTH; i++)
      if (mem[i] != 8'hFF) chk(0, "R3 pattern stored", mem[i], 8'hFF);
    quiet_after("R6 no request after pass");

    // restart pulse in the middle of a sweep is ignored
    prep(2, -1, '0);
    base = wr_cnt;
    pulse_start();
    repeat (300) @(negedge clk);
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    wait_end();
    chk(pass_o, "R9 mid-sweep start ignored, pass", pass_o, 1);
    chk(wr_cnt - base == 2*DEPTH, "R9 write count unchanged", wr_cnt - base, 2*DEPTH);

    // single-bit fault in bank 0
    prep(1, 5, 8'h01);
    base = wr_cnt;
    pulse_start();
    wait_end();
    chk(fail_o && !pass_o, "R7 fault bank0 detected", fail_o, 1);
    chk(faddr == 5, "R7 fail_addr bank0", faddr, 5);
    chk(wr_cnt - base == 6, "R7 sweep halted", wr_cnt - base, 6);
    quiet_after("R7 no request after fail");

    // fault at last location of bank 1
    prep(3, 2*DEPTH-1, 8'h80);
    pulse_start();
    wait_end();
    chk(fail_o, "R7 fault bank1 last detected", fail_o, 1);
    chk(faddr == ((1 << OW) | (DEPTH-1)), "R7 fail_addr bank1 last", faddr, (1 << OW) | (DEPTH-1));

    // read returns 0x00 at first location while bus idles at 0x00
    prep(0, 0, 8'hFF);
    pulse_start();
    wait_end();
    chk(fail_o, "R8 zero read fails", fail_o, 1);
    chk(faddr == 0, "R8 fail_addr offset0", faddr, 0);

    // restart after failure clears flags and passes
    prep(1, -1, '0);
    pulse_start();
    chk(!done_o && !fail_o && faddr == 0, "R2 flags cleared on start", {done_o, fail_o}, 0);
    wait_end();
    chk(pass_o && !fail_o, "R2 restart passes", pass_o, 1);
    chk(faddr == 0, "R2 fail_addr cleared", faddr, 0);

    finish_run();
  end
endmodule